// File: doc/BRIEF.md
# Floppy Controller Bus Bridge with Boot Overlay

This block sits between the 8-bit I/O space of a small CPU and an external floppy disk controller. An I/O cycle carries a 3-bit port offset. Most offsets pass straight through to one of the controller's four registers. The data bus is bit-inverted in both directions on the way through. One offset does not reach the controller. A write there loads a drive/side select latch. A read there drops the boot ROM overlay that covers the bottom of memory.

Writing the select latch with at least one drive bit set starts a motor window. The window lasts a fixed, parameterised number of clock cycles and restarts on every latch write. When the window runs out, the drive select bits clear. The overlay flag is set by reset. While it is set, CPU addresses below the overlay size select ROM instead of RAM. The CPU drops the overlay once, by a read of the select offset, and the flag stays clear until the next reset.

Top module: `fdc_glue`

## Requirements
- R1: During an access (io_sel_i high) at offset 0, 1, 2 or 3, fdc_cs_o is high, fdc_addr_o equals the offset and fdc_we_o equals io_wr_i, all in the same cycle.
- R2: During a controller access, fdc_wdata_o is the bitwise complement of io_wdata_i. On a read, io_rdata_o is the bitwise complement of fdc_rdata_i.
- R3: Offset 7 is a second path to controller register 3 (data). It asserts fdc_cs_o with fdc_addr_o = 3 and uses the same inversion in both directions.
- R4: A write at offset 6 does not touch the controller. At the next clock edge it loads drive_sel_o from io_wdata_i[3:0], with one bit per drive, and side_o from io_wdata_i[5].
- R5: After an offset-6 write with any of bits 3:0 set, motor_on_o is high for exactly MOTOR_CYCLES cycles, counted from the write's clock edge. Each such write restarts the full window, including a write on the edge where the window would have ended. A write with bits 3:0 all zero turns the motor off at once.
- R6: On the edge where the motor window runs out, drive_sel_o clears to 0. side_o keeps its value.
- R7: A read at offset 6 returns 0xFF on io_rdata_o and leaves fdc_cs_o low. From the next clock edge it clears the overlay flag (boot_rom_o low), and the flag stays clear until reset.
- R8: rom_sel_o is high exactly when boot_rom_o is high and mem_addr_i is below OVERLAY_BYTES (0x0400 by default).
- R9: Offsets 4 and 5 keep fdc_cs_o low. A read there returns 0x00. A write there leaves drive_sel_o, side_o and motor_on_o unchanged.
- R10: With no access in progress, io_rdata_o is 0x00 and fdc_cs_o is low.
- R11: After reset, drive_sel_o is 0, side_o is 0, motor_on_o is low and boot_rom_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 1 | I/O access strobe for this block |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 3 | Port offset |
| io_wdata_i | input | 8 | CPU write data |
| io_rdata_o | output | 8 | CPU read data |
| fdc_cs_o | output | 1 | Controller chip select |
| fdc_we_o | output | 1 | Controller write enable |
| fdc_addr_o | output | 2 | Controller register index |
| fdc_wdata_o | output | 8 | Inverted write data to the controller |
| fdc_rdata_i | input | 8 | Read data from the controller |
| drive_sel_o | output | DRIVES | Drive select bits, one per drive |
| side_o | output | 1 | Head side select |
| motor_on_o | output | 1 | Motor window active |
| mem_addr_i | input | ADDR_W | CPU memory address for the overlay decode |
| boot_rom_o | output | 1 | Overlay flag |
| rom_sel_o | output | 1 | Selects ROM for the current memory address |

## Verification
Two functions can fall on the same edge: a new write to the select latch, and the countdown reaching zero, which clears the drive bits. The bench arms the window and then waits exactly MOTOR_CYCLES-1 idle cycles. It then issues a second select write with a different drive, so that the write lands on the expiry edge. The collision is judged correct when motor_on_o never drops at that edge and drive_sel_o shows the new drive rather than zero. A fresh full window must then follow, with the motor dropping exactly MOTOR_CYCLES cycles after the second write.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

  typedef enum logic [2:0] {
    OFF_CMD     = 3'd0,
    OFF_TRK     = 3'd1,
    OFF_SEC     = 3'd2,
    OFF_DAT     = 3'd3,
    OFF_GAP_A   = 3'd4,
    OFF_GAP_B   = 3'd5,
    OFF_SEL     = 3'd6,
    OFF_DAT_ALT = 3'd7
  } port_off_e;

  localparam int SIDE_BIT = 5;

  typedef struct packed {
    logic       fdc_hit;
    logic       sel_wr;
    logic       ovl_rd;
    logic [1:0] reg_idx;
  } dec_t;

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
  import fdc_glue_pkg::*;
(
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  output dec_t       dec_o
);

  port_off_e off;

  always_comb begin
    off           = port_off_e'(addr_i);
    dec_o         = '0;
    dec_o.reg_idx = addr_i[1:0];
    if (sel_i) begin
      unique case (off)
        OFF_CMD, OFF_TRK, OFF_SEC, OFF_DAT, OFF_DAT_ALT: dec_o.fdc_hit = 1'b1;
        OFF_SEL: begin
          dec_o.sel_wr = wr_i;
          dec_o.ovl_rd = !wr_i;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fdc_drive_latch.sv
module fdc_drive_latch #(
  parameter int DRIVES       = 4,
  parameter int MOTOR_CYCLES = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DRIVES-1:0] drives_i,
  input  logic              side_i,
  output logic [DRIVES-1:0] drive_sel_o,
  output logic              side_o,
  output logic              motor_on_o
);

  localparam int CNT_W = $clog2(MOTOR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MOTOR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_sel_o <= '0;
      side_o      <= 1'b0;
      cnt_q       <= '0;
    end else if (load_i) begin
      // reload wins over expiry on the same edge
      drive_sel_o <= drives_i;
      side_o      <= side_i;
      cnt_q       <= (|drives_i) ? CNT_LOAD : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) drive_sel_o <= '0;
    end
  end

  assign motor_on_o = (cnt_q != '0);

endmodule

// File: rtl/fdc_boot_overlay.sv
module fdc_boot_overlay #(
  parameter int ADDR_W        = 16,
  parameter int OVERLAY_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              active_o,
  output logic              rom_sel_o
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(OVERLAY_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_o <= 1'b1;
    else if (clear_i) active_o <= 1'b0;
  end

  assign rom_sel_o = active_o && ({1'b0, mem_addr_i} < LIMIT);

endmodule

// File: rtl/fdc_glue.sv
module fdc_glue
  import fdc_glue_pkg::*;
#(
  parameter int DRIVES        = 4,
  parameter int MOTOR_CYCLES  = 300,
  parameter int ADDR_W        = 16,
  parameter int OVERLAY_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              io_wr_i,
  input  logic [2:0]        io_addr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              fdc_cs_o,
  output logic              fdc_we_o,
  output logic [1:0]        fdc_addr_o,
  output logic [7:0]        fdc_wdata_o,
  input  logic [7:0]        fdc_rdata_i,
  output logic [DRIVES-1:0] drive_sel_o,
  output logic              side_o,
  output logic              motor_on_o,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              boot_rom_o,
  output logic              rom_sel_o
);

  dec_t dec;

  fdc_port_decode u_dec (
    .sel_i  (io_sel_i),
    .wr_i   (io_wr_i),
    .addr_i (io_addr_i),
    .dec_o  (dec)
  );

  assign fdc_cs_o    = dec.fdc_hit;
  assign fdc_we_o    = dec.fdc_hit && io_wr_i;
  assign fdc_addr_o  = dec.reg_idx;
  assign fdc_wdata_o = ~io_wdata_i;

  always_comb begin
    if (dec.fdc_hit && !io_wr_i) io_rdata_o = ~fdc_rdata_i;
    else if (dec.ovl_rd)         io_rdata_o = 8'hFF;
    else                         io_rdata_o = 8'h00;
  end

  fdc_drive_latch #(
    .DRIVES       (DRIVES),
    .MOTOR_CYCLES (MOTOR_CYCLES)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (dec.sel_wr),
    .drives_i    (io_wdata_i[DRIVES-1:0]),
    .side_i      (io_wdata_i[SIDE_BIT]),
    .drive_sel_o (drive_sel_o),
    .side_o      (side_o),
    .motor_on_o  (motor_on_o)
  );

  fdc_boot_overlay #(
    .ADDR_W        (ADDR_W),
    .OVERLAY_BYTES (OVERLAY_BYTES)
  ) u_ovl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (dec.ovl_rd),
    .mem_addr_i (mem_addr_i),
    .active_o   (boot_rom_o),
    .rom_sel_o  (rom_sel_o)
  );

endmodule

// File: rtl/fdc_glue_chk.sv
module fdc_glue_chk #(
  parameter int DRIVES        = 4,
  parameter int MOTOR_CYCLES  = 300,
  parameter int ADDR_W        = 16,
  parameter int OVERLAY_BYTES = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_sel_i,
  input logic              io_wr_i,
  input logic [2:0]        io_addr_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              fdc_cs_o,
  input logic              fdc_we_o,
  input logic [1:0]        fdc_addr_o,
  input logic [7:0]        fdc_wdata_o,
  input logic [7:0]        fdc_rdata_i,
  input logic [DRIVES-1:0] drive_sel_o,
  input logic              side_o,
  input logic              motor_on_o,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              boot_rom_o,
  input logic              rom_sel_o
);

  logic [31:0] win_cnt;
  logic        sel_wr;
  assign sel_wr = io_sel_i && io_wr_i && (io_addr_i == 3'd6);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              win_cnt <= '0;
    else if (sel_wr)          win_cnt <= (|io_wdata_i[DRIVES-1:0]) ? 32'(MOTOR_CYCLES) : '0;
    else if (win_cnt != '0)   win_cnt <= win_cnt - 32'd1;
  end

  a_r1_reg_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_i && (io_addr_i < 3'd4) |->
      fdc_cs_o && (fdc_addr_o == io_addr_i[1:0]) && (fdc_we_o == io_wr_i));

  a_r2_wr_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdc_we_o |-> (fdc_wdata_o == ~io_wdata_i));

  a_r2_rd_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdc_cs_o && !io_wr_i |-> (io_rdata_o == ~fdc_rdata_i));

  a_r3_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_i && (io_addr_i == 3'd7) |-> fdc_cs_o && (fdc_addr_o == 2'd3));

  a_r4_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> (drive_sel_o == $past(io_wdata_i[DRIVES-1:0])) && (side_o == $past(io_wdata_i[5])));

  a_r5_motor_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motor_on_o == (win_cnt != '0));

  a_r6_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(motor_on_o) |-> (drive_sel_o == '0));

  a_r7_ovl_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_i && !io_wr_i && (io_addr_i == 3'd6) |-> (io_rdata_o == 8'hFF) && !fdc_cs_o);

  a_r7_ovl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_i && !io_wr_i && (io_addr_i == 3'd6) |=> !boot_rom_o);

  a_r7_ovl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_rom_o |=> !boot_rom_o);

  a_r8_rom_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o == (boot_rom_o && (32'(mem_addr_i) < 32'(OVERLAY_BYTES))));

  a_r9_gap_offsets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_i && (io_addr_i == 3'd4 || io_addr_i == 3'd5) |-> !fdc_cs_o && (io_rdata_o == 8'h00));

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_sel_i |-> !fdc_cs_o && (io_rdata_o == 8'h00));

endmodule

bind fdc_glue fdc_glue_chk #(
  .DRIVES        (DRIVES),
  .MOTOR_CYCLES  (MOTOR_CYCLES),
  .ADDR_W        (ADDR_W),
  .OVERLAY_BYTES (OVERLAY_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_sel_i    (io_sel_i),
  .io_wr_i     (io_wr_i),
  .io_addr_i   (io_addr_i),
  .io_wdata_i  (io_wdata_i),
  .io_rdata_o  (io_rdata_o),
  .fdc_cs_o    (fdc_cs_o),
  .fdc_we_o    (fdc_we_o),
  .fdc_addr_o  (fdc_addr_o),
  .fdc_wdata_o (fdc_wdata_o),
  .fdc_rdata_i (fdc_rdata_i),
  .drive_sel_o (drive_sel_o),
  .side_o      (side_o),
  .motor_on_o  (motor_on_o),
  .mem_addr_i  (mem_addr_i),
  .boot_rom_o  (boot_rom_o),
  .rom_sel_o   (rom_sel_o)
);

// File: tb/tb_fdc_glue.sv
module tb_fdc_glue;

  localparam int M = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        io_sel, io_wr;
  logic [2:0]  io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        fdc_cs, fdc_we;
  logic [1:0]  fdc_addr;
  logic [7:0]  fdc_wdata, fdc_rdata;
  logic [3:0]  drive_sel;
  logic        side, motor_on;
  logic [15:0] mem_addr;
  logic        boot_rom, rom_sel;

  fdc_glue #(.MOTOR_CYCLES(M)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_sel_i(io_sel), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .fdc_cs_o(fdc_cs), .fdc_we_o(fdc_we), .fdc_addr_o(fdc_addr),
    .fdc_wdata_o(fdc_wdata), .fdc_rdata_i(fdc_rdata),
    .drive_sel_o(drive_sel), .side_o(side), .motor_on_o(motor_on),
    .mem_addr_i(mem_addr), .boot_rom_o(boot_rom), .rom_sel_o(rom_sel)
  );

  localparam int P_RDATA = 0, P_CS = 1, P_WE = 2, P_ADDR = 3, P_WDATA = 4,
                 P_DRV = 5, P_SIDE = 6, P_MOTOR = 7, P_BOOT = 8, P_ROM = 9;

  typedef struct {
    int    due;
    int    probe;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  item_t keep[$];
  int    smp = 0;
  int    cur = 0;
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;

  function automatic logic [31:0] probe(int id);
    case (id)
      P_RDATA: return 32'(io_rdata);
      P_CS:    return 32'(fdc_cs);
      P_WE:    return 32'(fdc_we);
      P_ADDR:  return 32'(fdc_addr);
      P_WDATA: return 32'(fdc_wdata);
      P_DRV:   return 32'(drive_sel);
      P_SIDE:  return 32'(side);
      P_MOTOR: return 32'(motor_on);
      P_BOOT:  return 32'(boot_rom);
      default: return 32'(rom_sel);
    endcase
  endfunction

  task automatic exp_at(string tag, int due, int id, int val);
    item_t it;
    it.due = due; it.probe = id; it.exp = val; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: samples between edges, after state update, inputs still held
  initial begin
    forever begin
      @(posedge clk);
      #3;
      keep.delete();
      foreach (q[i]) begin
        if (q[i].due == smp) begin
          logic [31:0] act;
          act = probe(q[i].probe);
          checks++;
          if (act !== 32'(q[i].exp)) begin
            fails++;
            $display("FAIL %s probe=%0d sample=%0d actual=0x%0h expected=0x%0h",
                     q[i].tag, q[i].probe, smp, act, q[i].exp);
          end
        end else begin
          keep.push_back(q[i]);
        end
      end
      q = keep;
      smp++;
    end
  end

  task automatic acc(bit wr, bit [2:0] off, bit [7:0] wd, bit [7:0] frd);
    @(negedge clk);
    io_sel = 1'b1; io_wr = wr; io_addr = off; io_wdata = wd; fdc_rdata = frd;
    cur = smp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      io_sel = 1'b0;
      cur = smp;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int s;
    rst_n = 1'b0; io_sel = 1'b0; io_wr = 1'b0; io_addr = '0;
    io_wdata = '0; fdc_rdata = '0; mem_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state, R10 idle, R8 inside window
    idle(1);
    mem_addr = 16'h03FF;
    exp_at("R11", cur, P_DRV, 0);
    exp_at("R11", cur, P_SIDE, 0);
    exp_at("R11", cur, P_MOTOR, 0);
    exp_at("R11", cur, P_BOOT, 1);
    exp_at("R10", cur, P_RDATA, 0);
    exp_at("R10", cur, P_CS, 0);
    exp_at("R8",  cur, P_ROM, 1);
    idle(1);
    mem_addr = 16'h0400;
    exp_at("R8", cur, P_ROM, 0);

    // R1 / R2 register routing and inversion
    acc(1'b1, 3'd1, 8'h5A, 8'h00);
    exp_at("R1", cur, P_CS, 1); exp_at("R1", cur, P_WE, 1); exp_at("R1", cur, P_ADDR, 1);
    exp_at("R2", cur, P_WDATA, 8'hA5);
    acc(1'b0, 3'd2, 8'h00, 8'h3C);
    exp_at("R1", cur, P_CS, 1); exp_at("R1", cur, P_WE, 0); exp_at("R1", cur, P_ADDR, 2);
    exp_at("R2", cur, P_RDATA, 8'hC3);
    acc(1'b1, 3'd0, 8'h81, 8'h00);
    exp_at("R1", cur, P_ADDR, 0); exp_at("R1", cur, P_WE, 1);
    exp_at("R2", cur, P_WDATA, 8'h7E);
    acc(1'b0, 3'd3, 8'h00, 8'hF0);
    exp_at("R1", cur, P_ADDR, 3);
    exp_at("R2", cur, P_RDATA, 8'h0F);

    // R3 alias of data register
    acc(1'b1, 3'd7, 8'h0F, 8'h00);
    exp_at("R3", cur, P_CS, 1); exp_at("R3", cur, P_ADDR, 3);
    exp_at("R3", cur, P_WE, 1); exp_at("R3", cur, P_WDATA, 8'hF0);
    acc(1'b0, 3'd7, 8'h00, 8'h81);
    exp_at("R3", cur, P_ADDR, 3); exp_at("R3", cur, P_RDATA, 8'h7E);

    // R9 unmapped offsets
    acc(1'b0, 3'd4, 8'h00, 8'h55);
    exp_at("R9", cur, P_RDATA, 0); exp_at("R9", cur, P_CS, 0);
    acc(1'b1, 3'd5, 8'h2F, 8'h00);
    exp_at("R9", cur, P_CS, 0); exp_at("R9", cur, P_DRV, 0);
    exp_at("R9", cur, P_SIDE, 0); exp_at("R9", cur, P_MOTOR, 0);

    // R4 latch load, R5 window length, R6 deselect on expiry
    acc(1'b1, 3'd6, 8'h22, 8'h99);
    s = cur;
    exp_at("R4", s, P_DRV, 4'b0010); exp_at("R4", s, P_SIDE, 1); exp_at("R4", s, P_CS, 0);
    exp_at("R5", s, P_MOTOR, 1);
    exp_at("R5", s + M - 1, P_MOTOR, 1);
    exp_at("R5", s + M, P_MOTOR, 0);
    exp_at("R6", s + M, P_DRV, 0);
    exp_at("R6", s + M, P_SIDE, 1);
    idle(1);
    exp_at("R10", cur, P_RDATA, 0);
    idle(M + 1);

    // R5 reload landing on the expiry edge
    acc(1'b1, 3'd6, 8'h08, 8'h00);
    s = cur;
    idle(M - 1);
    exp_at("R5", cur, P_MOTOR, 1);
    acc(1'b1, 3'd6, 8'h01, 8'h00);
    exp_at("R5", cur, P_MOTOR, 1);
    exp_at("R6", cur, P_DRV, 4'b0001);
    exp_at("R5", s + 2 * M - 1, P_MOTOR, 1);
    exp_at("R5", s + 2 * M, P_MOTOR, 0);
    exp_at("R6", s + 2 * M, P_DRV, 0);
    idle(M + 2);

    // R5 zero-drive write stops motor at once
    acc(1'b1, 3'd6, 8'h04, 8'h00);
    exp_at("R5", cur, P_MOTOR, 1);
    idle(2);
    acc(1'b1, 3'd6, 8'h20, 8'h00);
    exp_at("R5", cur, P_MOTOR, 0);
    exp_at("R4", cur, P_DRV, 0);
    exp_at("R4", cur, P_SIDE, 1);

    // R7 overlay release, R8 decode follows flag
    idle(1);
    mem_addr = 16'h0010;
    exp_at("R8", cur, P_ROM, 1);
    exp_at("R7", cur, P_BOOT, 1);
    acc(1'b0, 3'd6, 8'h00, 8'h12);
    exp_at("R7", cur, P_RDATA, 8'hFF);
    exp_at("R7", cur, P_CS, 0);
    exp_at("R7", cur, P_BOOT, 0);
    exp_at("R8", cur, P_ROM, 0);
    idle(5);
    exp_at("R7", cur, P_BOOT, 0);
    exp_at("R8", cur, P_ROM, 0);
    idle(4);

    if (q.size() != 0) begin
      fails += q.size();
      $display("FAIL scoreboard: %0d expected items never checked (actual=%0d expected=0)",
               q.size(), q.size());
    end
    finish_run();
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired (actual=running expected=finished)");
      finish_run();
    end
  end

endmodule